// File: doc/BRIEF.md
# Start/Stop-Framed Configuration Frame Loader

This block sits behind a header parser in a configuration path. It receives the serial program bits one at a time and cuts them into fixed-length frames. Every frame opens with a single 0 start bit, carries `DATA_W` payload bits, and closes with three 1 stop bits. Once the three stop bits of a frame have arrived, the block presents the payload as a parallel word on a valid/ready output, together with the frame's zero-based position in the program.

The block counts delivered frames. When frame `NUM_FRAMES-1` has been handed over, it raises a memory-full flag. After that it expects a run of at least `POST_MIN` ones that closes the program. A wrong start bit, a wrong stop bit, or a zero that breaks the closing run sets a sticky error flag, and no further frames are delivered after that. A synchronous `clear` restarts the loader for a new program.

The input side follows valid/ready rules. A bit is taken on a rising edge where both `bit_valid` and `bit_ready` are high. The output side has one holding register, so back-pressure works as follows: while a frame word is waiting (`frame_valid` high and `frame_ready` low), the word and index stay frozen and `bit_ready` stays low. The serial stream therefore stalls rather than overruns. The default sizes are 71 payload bits, 197 frames and a 4-one closing run, which gives `(DATA_W+4)*NUM_FRAMES+4` program bits in total.

Top module: `cfl_frame_loader`

## Requirements
- R1: After reset, `bit_ready`=1, `frame_valid`=0, `mem_full`=0, `frame_err`=0 and `post_done`=0.
- R2: A frame is one 0 bit, then `DATA_W` payload bits, then three 1 bits. With `LSB_FIRST`=1 (default), the first payload bit received appears at `frame_word[0]` and the last at `frame_word[DATA_W-1]`.
- R3: `frame_valid` rises in the cycle after the third stop bit is taken. `frame_idx` gives the zero-based frame number, starting at 0 after reset or clear.
- R4: While `frame_valid`=1 and `frame_ready`=0, `frame_valid`, `frame_word` and `frame_idx` hold, and `bit_ready` is 0. A frame is consumed on a rising edge with `frame_valid` and `frame_ready` both high.
- R5: A 1 in the start-bit position sets `frame_err`. The flag is sticky until clear, and no frame is delivered afterwards.
- R6: A 0 in any of the three stop-bit positions sets `frame_err`, and that frame is not delivered.
- R7: `mem_full` rises in the cycle after frame `NUM_FRAMES-1` is consumed, and stays high until clear.
- R8: After the last frame, `POST_MIN` consecutive ones set `post_done`. A 0 before that run completes sets `frame_err` instead.
- R9: Once `post_done` is set, further bits are accepted and ignored: no frame is delivered and `frame_err` stays 0.
- R10: `clear` (synchronous, sampled on a rising edge) abandons any partial frame and restores the R1 state, and the next frame has index 0.
- R11: Cycles with `bit_valid`=0 take no bit, whatever the value of `bit_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart for a new program |
| bit_valid | input | 1 | Serial bit present |
| bit_ready | output | 1 | Loader can take a bit |
| bit_data | input | 1 | Serial bit value |
| frame_valid | output | 1 | Frame word waiting |
| frame_ready | input | 1 | Consumer takes the frame word |
| frame_word | output | DATA_W | Payload of the frame |
| frame_idx | output | IDX_W | Zero-based frame number |
| mem_full | output | 1 | All frames delivered |
| frame_err | output | 1 | Sticky framing error |
| post_done | output | 1 | Closing run of ones received |

## Verification
The bench builds the loader with an 8-bit payload, 3 frames and a 4-one closing run. With these sizes a full program is short enough to replay many times in one run. This brings the full flag, the closing run, the index wrap back to zero on clear, and the path after post_done within a few hundred cycles. A table of payload words drives two complete programs. Directed sequences then cover corrupt start and stop bits, a broken closing run, output back-pressure, input gaps and a mid-frame clear.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int STOP_BITS = 3;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_DATA  = 3'd1,
    ST_STOP  = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4,
    ST_ERR   = 3'd5
  } ldr_state_e;
endpackage

// File: rtl/cfl_field_shift.sv
module cfl_field_shift #(
  parameter int DATA_W    = 71,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nx;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign word_nx = {shift_bit, word_q[DATA_W-1:1]};
    end else begin : g_msb
      assign word_nx = {word_q[DATA_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (clear)    word_q <= '0;
    else if (shift_en) word_q <= word_nx;
  end

  assign word = word_q;
endmodule

// File: rtl/cfl_counters.sv
module cfl_counters
  import cfl_pkg::*;
#(
  parameter int DATA_W     = 71,
  parameter int NUM_FRAMES = 197,
  parameter int POST_MIN   = 4,
  localparam int CNT_MAX   = (DATA_W > STOP_BITS) ? DATA_W : STOP_BITS,
  localparam int CNT_W     = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int PCNT_W    = $clog2(POST_MIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  ldr_state_e       state,
  input  logic             take,
  input  logic             take_bit,
  input  logic             frame_done,
  output logic             data_last,
  output logic             stop_last,
  output logic             frame_last,
  output logic             post_last,
  output logic [IDX_W-1:0] frame_idx
);
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  frame_cnt_q;
  logic [PCNT_W-1:0] post_cnt_q;

  assign data_last  = (bit_cnt_q == CNT_W'(DATA_W - 1));
  assign stop_last  = (bit_cnt_q == CNT_W'(STOP_BITS - 1));
  assign frame_last = (frame_cnt_q == IDX_W'(NUM_FRAMES - 1));
  assign post_last  = (post_cnt_q == PCNT_W'(POST_MIN - 1));
  assign frame_idx  = frame_cnt_q;

  // Position inside the payload or the stop field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
    end else if (clear) begin
      bit_cnt_q <= '0;
    end else if (take) begin
      unique case (state)
        ST_DATA: bit_cnt_q <= data_last ? '0 : bit_cnt_q + 1'b1;
        ST_STOP: bit_cnt_q <= stop_last ? '0 : bit_cnt_q + 1'b1;
        default: bit_cnt_q <= '0;
      endcase
    end
  end

  // Number of the frame being assembled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        frame_cnt_q <= '0;
    else if (clear)                    frame_cnt_q <= '0;
    else if (frame_done && !frame_last) frame_cnt_q <= frame_cnt_q + 1'b1;
  end

  // Ones received in the closing run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt_q <= '0;
    end else if (clear) begin
      post_cnt_q <= '0;
    end else if (take && state == ST_POST) begin
      if (take_bit && !post_last) post_cnt_q <= post_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfl_seq.sv
module cfl_seq
  import cfl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic       take_bit,
  input  logic       data_last,
  input  logic       stop_last,
  input  logic       frame_last,
  input  logic       post_last,
  output ldr_state_e state,
  output logic       shift_en,
  output logic       frame_done
);
  ldr_state_e st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    if (take) begin
      unique case (st_q)
        ST_START: st_nx = take_bit ? ST_ERR : ST_DATA;
        ST_DATA:  if (data_last) st_nx = ST_STOP;
        ST_STOP: begin
          if (!take_bit)      st_nx = ST_ERR;
          else if (stop_last) st_nx = frame_last ? ST_POST : ST_START;
        end
        ST_POST: begin
          if (!take_bit)      st_nx = ST_ERR;
          else if (post_last) st_nx = ST_DONE;
        end
        ST_DONE:  st_nx = ST_DONE;
        ST_ERR:   st_nx = ST_ERR;
        default:  st_nx = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_START;
    else if (clear) st_q <= ST_START;
    else            st_q <= st_nx;
  end

  assign state      = st_q;
  assign shift_en   = take && (st_q == ST_DATA);
  assign frame_done = take && (st_q == ST_STOP) && take_bit && stop_last;
endmodule

// File: rtl/cfl_frame_loader.sv
module cfl_frame_loader
  import cfl_pkg::*;
#(
  parameter int DATA_W     = 71,
  parameter int NUM_FRAMES = 197,
  parameter int POST_MIN   = 4,
  parameter bit LSB_FIRST  = 1'b1,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_data,
  output logic              frame_valid,
  input  logic              frame_ready,
  output logic [DATA_W-1:0] frame_word,
  output logic [IDX_W-1:0]  frame_idx,
  output logic              mem_full,
  output logic              frame_err,
  output logic              post_done
);
  ldr_state_e        state;
  logic              take;
  logic              shift_en;
  logic              frame_done;
  logic              data_last;
  logic              stop_last;
  logic              frame_last;
  logic              post_last;
  logic [IDX_W-1:0]  cnt_idx;
  logic [DATA_W-1:0] asm_word;

  logic              out_valid_q;
  logic [DATA_W-1:0] out_word_q;
  logic [IDX_W-1:0]  out_idx_q;
  logic              full_q;

  assign bit_ready = !out_valid_q;
  assign take      = bit_valid && bit_ready;

  cfl_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .take       (take),
    .take_bit   (bit_data),
    .data_last  (data_last),
    .stop_last  (stop_last),
    .frame_last (frame_last),
    .post_last  (post_last),
    .state      (state),
    .shift_en   (shift_en),
    .frame_done (frame_done)
  );

  cfl_counters #(
    .DATA_W     (DATA_W),
    .NUM_FRAMES (NUM_FRAMES),
    .POST_MIN   (POST_MIN)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .state      (state),
    .take       (take),
    .take_bit   (bit_data),
    .frame_done (frame_done),
    .data_last  (data_last),
    .stop_last  (stop_last),
    .frame_last (frame_last),
    .post_last  (post_last),
    .frame_idx  (cnt_idx)
  );

  cfl_field_shift #(
    .DATA_W    (DATA_W),
    .LSB_FIRST (LSB_FIRST)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .shift_en  (shift_en),
    .shift_bit (bit_data),
    .word      (asm_word)
  );

  // Single holding register towards the consumer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
      out_idx_q   <= '0;
      full_q      <= 1'b0;
    end else if (clear) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
      out_idx_q   <= '0;
      full_q      <= 1'b0;
    end else begin
      if (frame_done) begin
        out_valid_q <= 1'b1;
        out_word_q  <= asm_word;
        out_idx_q   <= cnt_idx;
      end else if (out_valid_q && frame_ready) begin
        out_valid_q <= 1'b0;
        if (out_idx_q == IDX_W'(NUM_FRAMES - 1)) full_q <= 1'b1;
      end
    end
  end

  assign frame_valid = out_valid_q;
  assign frame_word  = out_word_q;
  assign frame_idx   = out_idx_q;
  assign mem_full    = full_q;
  assign frame_err   = (state == ST_ERR);
  assign post_done   = (state == ST_DONE);
endmodule

// File: rtl/cfl_frame_loader_chk.sv
module cfl_frame_loader_chk #(
  parameter int DATA_W     = 71,
  parameter int NUM_FRAMES = 197,
  parameter int IDX_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              bit_ready,
  input logic              frame_valid,
  input logic              frame_ready,
  input logic [DATA_W-1:0] frame_word,
  input logic [IDX_W-1:0]  frame_idx,
  input logic              mem_full,
  input logic              frame_err,
  input logic              post_done
);
  assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (frame_valid && !frame_ready) |=> (frame_valid && $stable(frame_word) && $stable(frame_idx)));

  assert_stall_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !bit_ready);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n || clear)
    frame_err |=> frame_err);

  assert_no_frame_after_err_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
    $rose(frame_valid) |-> !frame_err);

  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || clear)
    mem_full |=> mem_full);

  assert_full_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |-> !frame_valid);

  assert_post_after_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    post_done |-> (mem_full && !frame_err));

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (int'(frame_idx) < NUM_FRAMES));
endmodule

bind cfl_frame_loader cfl_frame_loader_chk #(
  .DATA_W     (DATA_W),
  .NUM_FRAMES (NUM_FRAMES),
  .IDX_W      (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear       (clear),
  .bit_ready   (bit_ready),
  .frame_valid (frame_valid),
  .frame_ready (frame_ready),
  .frame_word  (frame_word),
  .frame_idx   (frame_idx),
  .mem_full    (mem_full),
  .frame_err   (frame_err),
  .post_done   (post_done)
);

// File: tb/cfl_frame_loader_tb.sv
module cfl_frame_loader_tb;
  localparam int DW = 8;
  localparam int NF = 3;
  localparam int PM = 4;
  localparam int IW = 2;

  localparam logic [DW-1:0] VEC [0:5] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic frame_ready = 1'b1;
  logic bit_ready, frame_valid, mem_full, frame_err, post_done;
  logic [DW-1:0] frame_word;
  logic [IW-1:0] frame_idx;

  int checks = 0;
  int failures = 0;
  int hs_cnt = 0;

  always #2 clk = ~clk;

  cfl_frame_loader #(.DATA_W(DW), .NUM_FRAMES(NF), .POST_MIN(PM)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_word(frame_word), .frame_idx(frame_idx),
    .mem_full(mem_full), .frame_err(frame_err), .post_done(post_done)
  );

  always @(posedge clk) if (rst_n && frame_valid && frame_ready) hs_cnt <= hs_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    while (!bit_ready) @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    @(posedge clk);
    #1 bit_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [DW-1:0] w);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(w[i]);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bit_ready", int'(bit_ready), 1);
    chk("R1 frame_valid", int'(frame_valid), 0);
    chk("R1 mem_full", int'(mem_full), 0);
    chk("R1 frame_err", int'(frame_err), 0);
    chk("R1 post_done", int'(post_done), 0);

    // Table walk: two complete programs (R2, R3, R7, R8)
    for (int i = 0; i < 6; i++) begin
      if (i % NF == 0) pulse_clear();
      send_frame(VEC[i]);
      @(negedge clk);
      chk("R3 frame_valid", int'(frame_valid), 1);
      chk("R2 frame_word", int'(frame_word), int'(VEC[i]));
      chk("R3 frame_idx", int'(frame_idx), i % NF);
      chk("R7 full before last", int'(mem_full), 0);
      if (i % NF == NF - 1) begin
        @(negedge clk);
        chk("R7 mem_full", int'(mem_full), 1);
        for (int k = 0; k < PM - 1; k++) send_bit(1'b1);
        @(negedge clk);
        chk("R8 post_done early", int'(post_done), 0);
        send_bit(1'b1);
        @(negedge clk);
        chk("R8 post_done", int'(post_done), 1);
      end
    end

    // R9: bits after the closing run are ignored
    hs0 = hs_cnt;
    send_frame(8'h77);
    send_bit(1'b0);
    repeat (2) @(negedge clk);
    chk("R9 no frame", hs_cnt - hs0, 0);
    chk("R9 no error", int'(frame_err), 0);
    chk("R9 post_done kept", int'(post_done), 1);

    // R10: clear in the middle of a frame
    pulse_clear();
    send_bit(1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    pulse_clear();
    chk("R10 bit_ready", int'(bit_ready), 1);
    chk("R10 post_done", int'(post_done), 0);
    chk("R10 mem_full", int'(mem_full), 0);
    send_frame(8'h96);
    @(negedge clk);
    chk("R10 idx restart", int'(frame_idx), 0);
    chk("R10 word", int'(frame_word), 8'h96);

    // R4: back-pressure on the frame output
    @(negedge clk);
    frame_ready = 1'b0;
    send_frame(8'hC3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 valid held", int'(frame_valid), 1);
      chk("R4 word held", int'(frame_word), 8'hC3);
      chk("R4 idx held", int'(frame_idx), 1);
      chk("R4 bit_ready low", int'(bit_ready), 0);
    end
    frame_ready = 1'b1;
    @(negedge clk);
    chk("R4 consumed", int'(frame_valid), 0);

    // R11: gaps with bit_valid low and noise on bit_data
    pulse_clear();
    send_bit(1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      bit_data = k[0];
    end
    for (int i = 3; i < DW; i++) send_bit(1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    @(negedge clk);
    chk("R11 valid", int'(frame_valid), 1);
    chk("R11 word", int'(frame_word), 8'h07);

    // R5: bad start bit
    pulse_clear();
    send_bit(1'b1);
    @(negedge clk);
    chk("R5 frame_err", int'(frame_err), 1);
    hs0 = hs_cnt;
    send_frame(8'h11);
    repeat (2) @(negedge clk);
    chk("R5 no frame", hs_cnt - hs0, 0);
    chk("R5 err sticky", int'(frame_err), 1);

    // R6: bad stop bit
    pulse_clear();
    chk("R10 err cleared", int'(frame_err), 0);
    hs0 = hs_cnt;
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    repeat (2) @(negedge clk);
    chk("R6 frame_err", int'(frame_err), 1);
    chk("R6 no frame", hs_cnt - hs0, 0);

    // R8: broken closing run
    pulse_clear();
    for (int i = 0; i < NF; i++) send_frame(VEC[i]);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    @(negedge clk);
    chk("R8 broken run err", int'(frame_err), 1);
    chk("R8 broken run done", int'(post_done), 0);
    chk("R7 full kept", int'(mem_full), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule